// File: doc/BRIEF.md
# USB Endpoint Packet Buffer Manager

This block sits on the USB side of a dual-port packet SRAM. It places every endpoint's data in a region of that one shared memory. When the serial interface engine asks to move a packet for an endpoint, the block looks up that endpoint's descriptor. If the buffer is handed to the USB side, it accepts the request. It then produces one SRAM address per byte, starting at the buffer base and rising by one, and it counts the bytes moved. Received bytes that do not fit in the buffer are not written.

Software arms a buffer by writing its descriptor: a base address, a size for receive or a byte count for transmit, and a double-buffer flag. At the end of the packet the block writes the final count back into the descriptor, raises a done flag and returns the buffer to software. On a double-buffered endpoint it also flips the buffer select, so the next packet goes to the other buffer. A request that finds its buffer still held by software gets a not-ready reply, which the engine turns into a NAK.

Top module: `usb_pbm_mgr`

## Requirements
- R1: After reset, no slot is owned by the USB side, every done and overrun flag is 0, every buffer select is 0, `sie_ack` and `sie_nak` are 0, and no SRAM read or write is issued.
- R2: A descriptor write to a slot not held by the USB side stores the base, the size and the double-buffer flag. It hands the slot to the USB side (`rd_own`=1) and clears that slot's done and overrun flags.
- R3: `sie_start` in idle selects slot `sel` of the endpoint if it is double-buffered, and slot 0 if it is not. One cycle later the block pulses `sie_ack` if that slot is USB-owned, or `sie_nak` if it is not. A NAK leaves the block idle, so bytes that follow cause no SRAM access.
- R4: Receive bytes (`sie_dir`=0) are written to base, base+1, base+2 and so on, in the same cycle as `sie_byte`. Addresses wrap modulo 2^ADDR_W.
- R5: When the count of a receive packet equals the buffer size, further bytes cause no SRAM write, and the slot's overrun flag is 1 after completion.
- R6: Each transmit byte request (`sie_dir`=1) reads base+count, and the data appears on `sie_rdata` in the next cycle. Once count equals the programmed byte count, `sie_tx_empty` is 1 and requests issue no read.
- R7: `sie_end` completes the packet. The slot's count becomes the number of bytes moved, including a byte accepted in the `sie_end` cycle. Done becomes 1 and ownership returns to software.
- R8: Completion on a double-buffered endpoint toggles its buffer select. On a single-buffered endpoint the select stays 0.
- R9: A descriptor write to a slot held by the USB side is ignored. The next packet uses the old base.
- R10: A completion and an accepted descriptor write to the other slot of the same endpoint, in the same cycle, both take full effect.
- R11: `sie_start` while a packet is active produces neither `sie_ack` nor `sie_nak`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_ep | input | EP_W | Endpoint of descriptor write |
| cfg_slot | input | 1 | Buffer slot (0/1) of descriptor write |
| cfg_base | input | ADDR_W | Buffer base address |
| cfg_size | input | CNT_W | Receive buffer size or transmit byte count |
| cfg_dbl | input | 1 | Double-buffer enable for the endpoint |
| rd_ep | input | EP_W | Endpoint of status readback |
| rd_slot | input | 1 | Slot of status readback |
| rd_count | output | CNT_W | Byte count written back at completion |
| rd_done | output | 1 | Slot completed a packet |
| rd_ovr | output | 1 | Receive overrun on slot |
| rd_own | output | 1 | Slot held by USB side |
| rd_sel | output | 1 | Endpoint buffer select |
| sie_start | input | 1 | Packet request |
| sie_ep | input | EP_W | Requested endpoint |
| sie_dir | input | 1 | 1 = transmit, 0 = receive |
| sie_byte | input | 1 | Byte strobe (receive data / transmit request) |
| sie_end | input | 1 | End of packet |
| sie_wdata | input | 8 | Receive byte |
| sie_rdata | output | 8 | Transmit byte, one cycle after request |
| sie_ack | output | 1 | Request accepted |
| sie_nak | output | 1 | Request refused, buffer not ready |
| sie_tx_empty | output | 1 | Transmit count exhausted |
| sram_addr | output | ADDR_W | SRAM byte address |
| sram_we | output | 1 | SRAM write enable |
| sram_re | output | 1 | SRAM read enable |
| sram_wdata | output | 8 | SRAM write data |
| sram_rdata | input | 8 | SRAM read data (registered, one-cycle latency) |

## Verification
A packet completion and a software descriptor write can land on the same endpoint in the same cycle. Both change that endpoint's ownership and buffer select. The bench drives `sie_end` for slot 0 of a double-buffered endpoint in the cycle where software arms slot 1. It then checks that slot 0 holds its count and done flag, that slot 1 is owned, that the select has flipped, and that the next packet is accepted at slot 1's new base. A write aimed at the slot the USB side is still using is also issued, and it must leave the old base in force.

// File: rtl/usb_pbm_pkg.sv
package usb_pbm_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_XFER = 1'b1
  } eng_state_e;

  localparam logic DIR_RX = 1'b0;
  localparam logic DIR_TX = 1'b1;
endpackage

// File: rtl/usb_pbm_slot.sv
module usb_pbm_slot #(
  parameter int ADDR_W = 11,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_hit,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [CNT_W-1:0]  cfg_size,
  input  logic              cmp_hit,
  input  logic [CNT_W-1:0]  cmp_count,
  input  logic              cmp_ovr,
  output logic [ADDR_W-1:0] base,
  output logic [CNT_W-1:0]  size,
  output logic [CNT_W-1:0]  count,
  output logic              own,
  output logic              done,
  output logic              ovr
);
  logic [ADDR_W-1:0] base_n;
  logic [CNT_W-1:0]  size_n, count_n;
  logic              own_n, done_n, ovr_n;
  logic              en;

  assign en = cfg_hit | cmp_hit;

  always_comb begin
    base_n  = base;
    size_n  = size;
    count_n = count;
    own_n   = own;
    done_n  = done;
    ovr_n   = ovr;
    if (cmp_hit) begin
      count_n = cmp_count;
      done_n  = 1'b1;
      own_n   = 1'b0;
      ovr_n   = cmp_ovr;
    end else if (cfg_hit) begin
      base_n  = cfg_base;
      size_n  = cfg_size;
      own_n   = 1'b1;
      done_n  = 1'b0;
      ovr_n   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base  <= '0;
      size  <= '0;
      count <= '0;
      own   <= 1'b0;
      done  <= 1'b0;
      ovr   <= 1'b0;
    end else if (en) begin
      base  <= base_n;
      size  <= size_n;
      count <= count_n;
      own   <= own_n;
      done  <= done_n;
      ovr   <= ovr_n;
    end
  end
endmodule

// File: rtl/usb_pbm_desc.sv
module usb_pbm_desc #(
  parameter int NUM_EP = 8,
  parameter int EP_W   = 3,
  parameter int ADDR_W = 11,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [EP_W-1:0]   cfg_ep,
  input  logic              cfg_slot,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [CNT_W-1:0]  cfg_size,
  input  logic              cfg_dbl,
  input  logic [EP_W-1:0]   lk_ep,
  output logic              lk_slot,
  output logic [ADDR_W-1:0] lk_base,
  output logic [CNT_W-1:0]  lk_size,
  output logic              lk_own,
  input  logic              cmp_valid,
  input  logic [EP_W-1:0]   cmp_ep,
  input  logic              cmp_slot,
  input  logic [CNT_W-1:0]  cmp_count,
  input  logic              cmp_ovr,
  input  logic [EP_W-1:0]   rd_ep,
  input  logic              rd_slot,
  output logic [CNT_W-1:0]  rd_count,
  output logic              rd_done,
  output logic              rd_ovr,
  output logic              rd_own,
  output logic              rd_sel
);
  localparam int NSLOT = 2;

  logic [ADDR_W-1:0] s_base  [NUM_EP][NSLOT];
  logic [CNT_W-1:0]  s_size  [NUM_EP][NSLOT];
  logic [CNT_W-1:0]  s_count [NUM_EP][NSLOT];
  logic              s_own   [NUM_EP][NSLOT];
  logic              s_done  [NUM_EP][NSLOT];
  logic              s_ovr   [NUM_EP][NSLOT];
  logic              s_cfg   [NUM_EP][NSLOT];
  logic              s_cmp   [NUM_EP][NSLOT];
  logic              ep_dbl  [NUM_EP];
  logic              ep_sel  [NUM_EP];

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    logic dbl_q, sel_q, dbl_n, sel_n, cfg_acc, cmp_ep_hit, ep_en;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      assign s_cfg[e][s] = cfg_we && (cfg_ep == EP_W'(e)) &&
                           (cfg_slot == 1'(s)) && !s_own[e][s];
      assign s_cmp[e][s] = cmp_valid && (cmp_ep == EP_W'(e)) &&
                           (cmp_slot == 1'(s));

      usb_pbm_slot #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) slot_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_hit   (s_cfg[e][s]),
        .cfg_base  (cfg_base),
        .cfg_size  (cfg_size),
        .cmp_hit   (s_cmp[e][s]),
        .cmp_count (cmp_count),
        .cmp_ovr   (cmp_ovr),
        .base      (s_base[e][s]),
        .size      (s_size[e][s]),
        .count     (s_count[e][s]),
        .own       (s_own[e][s]),
        .done      (s_done[e][s]),
        .ovr       (s_ovr[e][s])
      );
    end

    assign cfg_acc    = s_cfg[e][0] | s_cfg[e][1];
    assign cmp_ep_hit = s_cmp[e][0] | s_cmp[e][1];
    assign ep_en      = cfg_acc | cmp_ep_hit;

    always_comb begin
      dbl_n = dbl_q;
      sel_n = sel_q;
      if (cmp_ep_hit && dbl_q) sel_n = ~sel_q;
      if (cfg_acc) begin
        dbl_n = cfg_dbl;
        if (!cfg_dbl) sel_n = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dbl_q <= 1'b0;
        sel_q <= 1'b0;
      end else if (ep_en) begin
        dbl_q <= dbl_n;
        sel_q <= sel_n;
      end
    end

    assign ep_dbl[e] = dbl_q;
    assign ep_sel[e] = sel_q;
  end

  always_comb begin
    lk_slot = ep_dbl[lk_ep] ? ep_sel[lk_ep] : 1'b0;
    lk_base = s_base[lk_ep][lk_slot];
    lk_size = s_size[lk_ep][lk_slot];
    lk_own  = s_own[lk_ep][lk_slot];
  end

  assign rd_count = s_count[rd_ep][rd_slot];
  assign rd_done  = s_done[rd_ep][rd_slot];
  assign rd_ovr   = s_ovr[rd_ep][rd_slot];
  assign rd_own   = s_own[rd_ep][rd_slot];
  assign rd_sel   = ep_sel[rd_ep];
endmodule

// File: rtl/usb_pbm_engine.sv
module usb_pbm_engine
  import usb_pbm_pkg::*;
#(
  parameter int EP_W   = 3,
  parameter int ADDR_W = 11,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sie_start,
  input  logic [EP_W-1:0]   sie_ep,
  input  logic              sie_dir,
  input  logic              sie_byte,
  input  logic              sie_end,
  input  logic [7:0]        sie_wdata,
  output logic              sie_ack,
  output logic              sie_nak,
  output logic              sie_tx_empty,
  output logic [EP_W-1:0]   lk_ep,
  input  logic              lk_slot,
  input  logic [ADDR_W-1:0] lk_base,
  input  logic [CNT_W-1:0]  lk_size,
  input  logic              lk_own,
  output logic              cmp_valid,
  output logic [EP_W-1:0]   cmp_ep,
  output logic              cmp_slot,
  output logic [CNT_W-1:0]  cmp_count,
  output logic              cmp_ovr,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_we,
  output logic              sram_re,
  output logic [7:0]        sram_wdata,
  output logic              eng_active,
  output logic [CNT_W-1:0]  eng_cnt,
  output logic [CNT_W-1:0]  eng_lim
);
  eng_state_e        state_q, state_n;
  logic [EP_W-1:0]   ep_q, ep_n;
  logic              slot_q, slot_n, dir_q, dir_n;
  logic [ADDR_W-1:0] base_q, base_n;
  logic [CNT_W-1:0]  lim_q, lim_n, cnt_q, cnt_n;
  logic              ovr_q, ovr_n, ack_q, ack_n, nak_q, nak_n;
  logic              xfer, room, moved;

  assign xfer  = (state_q == ST_XFER);
  assign room  = (cnt_q < lim_q);
  assign lk_ep = sie_ep;

  assign sram_we    = xfer && sie_byte && (dir_q == DIR_RX) && room;
  assign sram_re    = xfer && sie_byte && (dir_q == DIR_TX) && room;
  assign sram_addr  = base_q + ADDR_W'(cnt_q);
  assign sram_wdata = sie_wdata;
  assign moved      = sram_we | sram_re;

  assign sie_tx_empty = xfer && (dir_q == DIR_TX) && !room;
  assign sie_ack      = ack_q;
  assign sie_nak      = nak_q;

  always_comb begin
    state_n = state_q;
    ep_n    = ep_q;
    slot_n  = slot_q;
    dir_n   = dir_q;
    base_n  = base_q;
    lim_n   = lim_q;
    cnt_n   = cnt_q + CNT_W'(moved);
    ovr_n   = ovr_q | (xfer && sie_byte && (dir_q == DIR_RX) && !room);
    ack_n   = 1'b0;
    nak_n   = 1'b0;
    if (!xfer) begin
      cnt_n = cnt_q;
      ovr_n = ovr_q;
      if (sie_start) begin
        if (lk_own) begin
          state_n = ST_XFER;
          ep_n    = sie_ep;
          slot_n  = lk_slot;
          dir_n   = sie_dir;
          base_n  = lk_base;
          lim_n   = lk_size;
          cnt_n   = '0;
          ovr_n   = 1'b0;
          ack_n   = 1'b1;
        end else begin
          nak_n   = 1'b1;
        end
      end
    end else if (sie_end) begin
      state_n = ST_IDLE;
    end
  end

  assign cmp_valid = xfer && sie_end;
  assign cmp_ep    = ep_q;
  assign cmp_slot  = slot_q;
  assign cmp_count = cnt_q + CNT_W'(moved);
  assign cmp_ovr   = ovr_q | (xfer && sie_byte && (dir_q == DIR_RX) && !room);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ep_q    <= '0;
      slot_q  <= 1'b0;
      dir_q   <= DIR_RX;
      base_q  <= '0;
      lim_q   <= '0;
      cnt_q   <= '0;
      ovr_q   <= 1'b0;
      ack_q   <= 1'b0;
      nak_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      ep_q    <= ep_n;
      slot_q  <= slot_n;
      dir_q   <= dir_n;
      base_q  <= base_n;
      lim_q   <= lim_n;
      cnt_q   <= cnt_n;
      ovr_q   <= ovr_n;
      ack_q   <= ack_n;
      nak_q   <= nak_n;
    end
  end

  assign eng_active = xfer;
  assign eng_cnt    = cnt_q;
  assign eng_lim    = lim_q;
endmodule

// File: rtl/usb_pbm_mgr.sv
module usb_pbm_mgr #(
  parameter int NUM_EP = 8,
  parameter int ADDR_W = 11,
  parameter int CNT_W  = 10,
  localparam int EP_W  = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [EP_W-1:0]   cfg_ep,
  input  logic              cfg_slot,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [CNT_W-1:0]  cfg_size,
  input  logic              cfg_dbl,
  input  logic [EP_W-1:0]   rd_ep,
  input  logic              rd_slot,
  output logic [CNT_W-1:0]  rd_count,
  output logic              rd_done,
  output logic              rd_ovr,
  output logic              rd_own,
  output logic              rd_sel,
  input  logic              sie_start,
  input  logic [EP_W-1:0]   sie_ep,
  input  logic              sie_dir,
  input  logic              sie_byte,
  input  logic              sie_end,
  input  logic [7:0]        sie_wdata,
  output logic [7:0]        sie_rdata,
  output logic              sie_ack,
  output logic              sie_nak,
  output logic              sie_tx_empty,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_we,
  output logic              sram_re,
  output logic [7:0]        sram_wdata,
  input  logic [7:0]        sram_rdata
);
  logic [1:0]        rs_q;
  logic              rst_n_s;
  logic [EP_W-1:0]   lk_ep, cmp_ep;
  logic              lk_slot, lk_own, cmp_valid, cmp_slot, cmp_ovr;
  logic [ADDR_W-1:0] lk_base;
  logic [CNT_W-1:0]  lk_size, cmp_count;
  logic              eng_active;
  logic [CNT_W-1:0]  eng_cnt, eng_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  assign sie_rdata = sram_rdata;

  usb_pbm_desc #(
    .NUM_EP(NUM_EP), .EP_W(EP_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) desc_i (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .cfg_we    (cfg_we),
    .cfg_ep    (cfg_ep),
    .cfg_slot  (cfg_slot),
    .cfg_base  (cfg_base),
    .cfg_size  (cfg_size),
    .cfg_dbl   (cfg_dbl),
    .lk_ep     (lk_ep),
    .lk_slot   (lk_slot),
    .lk_base   (lk_base),
    .lk_size   (lk_size),
    .lk_own    (lk_own),
    .cmp_valid (cmp_valid),
    .cmp_ep    (cmp_ep),
    .cmp_slot  (cmp_slot),
    .cmp_count (cmp_count),
    .cmp_ovr   (cmp_ovr),
    .rd_ep     (rd_ep),
    .rd_slot   (rd_slot),
    .rd_count  (rd_count),
    .rd_done   (rd_done),
    .rd_ovr    (rd_ovr),
    .rd_own    (rd_own),
    .rd_sel    (rd_sel)
  );

  usb_pbm_engine #(
    .EP_W(EP_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) eng_i (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .sie_start    (sie_start),
    .sie_ep       (sie_ep),
    .sie_dir      (sie_dir),
    .sie_byte     (sie_byte),
    .sie_end      (sie_end),
    .sie_wdata    (sie_wdata),
    .sie_ack      (sie_ack),
    .sie_nak      (sie_nak),
    .sie_tx_empty (sie_tx_empty),
    .lk_ep        (lk_ep),
    .lk_slot      (lk_slot),
    .lk_base      (lk_base),
    .lk_size      (lk_size),
    .lk_own       (lk_own),
    .cmp_valid    (cmp_valid),
    .cmp_ep       (cmp_ep),
    .cmp_slot     (cmp_slot),
    .cmp_count    (cmp_count),
    .cmp_ovr      (cmp_ovr),
    .sram_addr    (sram_addr),
    .sram_we      (sram_we),
    .sram_re      (sram_re),
    .sram_wdata   (sram_wdata),
    .eng_active   (eng_active),
    .eng_cnt      (eng_cnt),
    .eng_lim      (eng_lim)
  );
endmodule

// File: rtl/usb_pbm_chk.sv
module usb_pbm_chk #(
  parameter int ADDR_W = 11,
  parameter int CNT_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sie_start,
  input logic              sie_ack,
  input logic              sie_nak,
  input logic              sram_we,
  input logic              sram_re,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              eng_active,
  input logic [CNT_W-1:0]  eng_cnt,
  input logic [CNT_W-1:0]  eng_lim
);
  assert_ack_nak_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sie_ack, sie_nak}));

  assert_reply_follows_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sie_ack || sie_nak) |-> $past(sie_start));

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_we && $past(sram_we) && eng_active && $past(eng_active)) |->
      (sram_addr == ADDR_W'($past(sram_addr) + 1'b1)));

  assert_cnt_within_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_active |-> (eng_cnt <= eng_lim));

  assert_rd_wr_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sram_we, sram_re}));

  assert_start_busy_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sie_start && eng_active) |=> !(sie_ack || sie_nak));
endmodule

bind usb_pbm_mgr usb_pbm_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .sie_start  (sie_start),
  .sie_ack    (sie_ack),
  .sie_nak    (sie_nak),
  .sram_we    (sram_we),
  .sram_re    (sram_re),
  .sram_addr  (sram_addr),
  .eng_active (eng_active),
  .eng_cnt    (eng_cnt),
  .eng_lim    (eng_lim)
);

// File: tb/usb_pbm_mgr_tb_top.sv
`timescale 1ns/1ps
module usb_pbm_mgr_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_EP = 8;
  localparam int ADDR_W = 11;
  localparam int CNT_W  = 10;
  localparam int EP_W   = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we, cfg_slot, cfg_dbl;
  logic [EP_W-1:0] cfg_ep, rd_ep, sie_ep;
  logic [ADDR_W-1:0] cfg_base, sram_addr;
  logic [CNT_W-1:0] cfg_size, rd_count;
  logic rd_slot, rd_done, rd_ovr, rd_own, rd_sel;
  logic sie_start, sie_dir, sie_byte, sie_end;
  logic [7:0] sie_wdata, sie_rdata, sram_wdata, sram_rdata;
  logic sie_ack, sie_nak, sie_tx_empty, sram_we, sram_re;

  int checks = 0;
  int errors = 0;
  logic [7:0] mem [2048];

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_pbm_mgr #(.NUM_EP(NUM_EP), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_ep(cfg_ep), .cfg_slot(cfg_slot), .cfg_base(cfg_base),
    .cfg_size(cfg_size), .cfg_dbl(cfg_dbl),
    .rd_ep(rd_ep), .rd_slot(rd_slot), .rd_count(rd_count), .rd_done(rd_done),
    .rd_ovr(rd_ovr), .rd_own(rd_own), .rd_sel(rd_sel),
    .sie_start(sie_start), .sie_ep(sie_ep), .sie_dir(sie_dir), .sie_byte(sie_byte),
    .sie_end(sie_end), .sie_wdata(sie_wdata), .sie_rdata(sie_rdata),
    .sie_ack(sie_ack), .sie_nak(sie_nak), .sie_tx_empty(sie_tx_empty),
    .sram_addr(sram_addr), .sram_we(sram_we), .sram_re(sram_re),
    .sram_wdata(sram_wdata), .sram_rdata(sram_rdata)
  );

  // SRAM model: write on edge, registered read
  always @(posedge clk) begin
    if (sram_we) mem[sram_addr] <= sram_wdata;
    if (sram_re) sram_rdata <= mem[sram_addr];
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic cfg_write(input int ep, input int slot, input int base,
                           input int size, input logic dbl);
    cfg_we = 1'b1; cfg_ep = EP_W'(ep); cfg_slot = 1'(slot);
    cfg_base = ADDR_W'(base); cfg_size = CNT_W'(size); cfg_dbl = dbl;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic status(input int ep, input int slot);
    rd_ep = EP_W'(ep); rd_slot = 1'(slot);
    settle();
  endtask

  task automatic request(input int ep, input logic dir);
    sie_start = 1'b1; sie_ep = EP_W'(ep); sie_dir = dir;
    tick();
    sie_start = 1'b0;
  endtask

  task automatic rx_byte(input logic [7:0] d, input int exp_addr,
                         input logic exp_we, input string tag);
    sie_byte = 1'b1; sie_wdata = d;
    settle();
    check({tag, " we"}, int'(sram_we), int'(exp_we));
    if (exp_we) check({tag, " addr"}, int'(sram_addr), exp_addr);
    tick();
    sie_byte = 1'b0;
  endtask

  task automatic finish_pkt();
    sie_end = 1'b1;
    tick();
    sie_end = 1'b0;
  endtask

  task automatic t_reset();
    status(0, 0);
    check("R1 own", int'(rd_own), 0);
    check("R1 done", int'(rd_done), 0);
    check("R1 ovr", int'(rd_ovr), 0);
    check("R1 sel", int'(rd_sel), 0);
    check("R1 ack/nak", int'({sie_ack, sie_nak}), 0);
    check("R1 sram", int'({sram_we, sram_re}), 0);
  endtask

  task automatic t_nak_unarmed();
    request(1, 1'b0);
    check("R3 nak unarmed", int'(sie_nak), 1);
    check("R3 no ack unarmed", int'(sie_ack), 0);
    rx_byte(8'h11, 0, 1'b0, "R3 idle after nak");
  endtask

  task automatic t_rx_wrap();
    cfg_write(1, 0, 'h7FE, 4, 1'b0);
    status(1, 0);
    check("R2 own after arm", int'(rd_own), 1);
    check("R2 done cleared", int'(rd_done), 0);
    request(1, 1'b0);
    check("R3 ack armed", int'(sie_ack), 1);
    rx_byte(8'h5A, 'h7FE, 1'b1, "R4 byte0");
    rx_byte(8'h5B, 'h7FF, 1'b1, "R4 byte1");
    rx_byte(8'h5C, 'h000, 1'b1, "R4 wrap byte2");
    finish_pkt();
    status(1, 0);
    check("R7 count", int'(rd_count), 3);
    check("R7 done", int'(rd_done), 1);
    check("R7 own back", int'(rd_own), 0);
    check("R5 no ovr", int'(rd_ovr), 0);
    check("R8 single sel", int'(rd_sel), 0);
    check("R4 mem 7FF", int'(mem['h7FF]), 'h5B);
    check("R4 mem 000", int'(mem['h000]), 'h5C);
  endtask

  task automatic t_overrun();
    mem['h102] = 8'hEE;
    cfg_write(2, 0, 'h100, 2, 1'b0);
    request(2, 1'b0);
    check("R3 ack ep2", int'(sie_ack), 1);
    rx_byte(8'h01, 'h100, 1'b1, "R5 in0");
    // start while busy must draw no reply
    sie_start = 1'b1; sie_ep = 3'd2; sie_dir = 1'b0;
    tick();
    sie_start = 1'b0;
    check("R11 busy start", int'({sie_ack, sie_nak}), 0);
    rx_byte(8'h02, 'h101, 1'b1, "R5 in1");
    rx_byte(8'h03, 0, 1'b0, "R5 extra0");
    sie_byte = 1'b1; sie_wdata = 8'h04; sie_end = 1'b1;
    settle();
    check("R5 extra at end", int'(sram_we), 0);
    tick();
    sie_byte = 1'b0; sie_end = 1'b0;
    status(2, 0);
    check("R5 count capped", int'(rd_count), 2);
    check("R5 ovr set", int'(rd_ovr), 1);
    check("R5 mem untouched", int'(mem['h102]), 'hEE);
    cfg_write(2, 0, 'h100, 2, 1'b0);
    status(2, 0);
    check("R2 ovr cleared", int'(rd_ovr), 0);
    check("R2 done cleared re-arm", int'(rd_done), 0);
  endtask

  task automatic t_tx();
    mem['h200] = 8'hA1; mem['h201] = 8'hB2; mem['h202] = 8'hC3;
    cfg_write(3, 0, 'h200, 3, 1'b0);
    request(3, 1'b1);
    check("R3 ack tx", int'(sie_ack), 1);
    for (int i = 0; i < 3; i++) begin
      sie_byte = 1'b1;
      settle();
      check("R6 re", int'(sram_re), 1);
      check("R6 addr", int'(sram_addr), 'h200 + i);
      tick();
      sie_byte = 1'b0;
      check("R6 rdata", int'(sie_rdata), int'(mem['h200 + i]));
    end
    check("R6 empty", int'(sie_tx_empty), 1);
    sie_byte = 1'b1;
    settle();
    check("R6 no read past count", int'(sram_re), 0);
    sie_byte = 1'b0;
    finish_pkt();
    status(3, 0);
    check("R7 tx count", int'(rd_count), 3);
    check("R7 tx done", int'(rd_done), 1);
  endtask

  task automatic t_double();
    cfg_write(4, 0, 'h300, 8, 1'b1);
    cfg_write(4, 1, 'h380, 8, 1'b1);
    request(4, 1'b0);
    check("R3 ack dbl a", int'(sie_ack), 1);
    rx_byte(8'h31, 'h300, 1'b1, "R8 slot0 addr");
    finish_pkt();
    status(4, 0);
    check("R8 sel toggled", int'(rd_sel), 1);
    request(4, 1'b0);
    check("R3 ack dbl b", int'(sie_ack), 1);
    rx_byte(8'h32, 'h380, 1'b1, "R8 slot1 addr");
    finish_pkt();
    status(4, 1);
    check("R8 sel back", int'(rd_sel), 0);
    check("R7 slot1 done", int'(rd_done), 1);
    request(4, 1'b0);
    check("R3 nak sw owned", int'(sie_nak), 1);
    cfg_write(4, 0, 'h300, 8, 1'b1);
    cfg_write(4, 0, 'h3C0, 8, 1'b1);
    request(4, 1'b0);
    rx_byte(8'h33, 'h300, 1'b1, "R9 owned write ignored");
    // completion of slot0 and arming of slot1 in one cycle
    sie_end = 1'b1;
    cfg_we = 1'b1; cfg_ep = 3'd4; cfg_slot = 1'b1;
    cfg_base = 11'h390; cfg_size = 10'd8; cfg_dbl = 1'b1;
    tick();
    sie_end = 1'b0; cfg_we = 1'b0;
    status(4, 0);
    check("R10 slot0 count", int'(rd_count), 1);
    check("R10 slot0 done", int'(rd_done), 1);
    check("R10 sel", int'(rd_sel), 1);
    status(4, 1);
    check("R10 slot1 own", int'(rd_own), 1);
    request(4, 1'b0);
    check("R10 ack slot1", int'(sie_ack), 1);
    rx_byte(8'h34, 'h390, 1'b1, "R10 slot1 new base");
    finish_pkt();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_we = 0; cfg_ep = 0; cfg_slot = 0; cfg_base = 0; cfg_size = 0; cfg_dbl = 0;
    rd_ep = 0; rd_slot = 0;
    sie_start = 0; sie_ep = 0; sie_dir = 0; sie_byte = 0; sie_end = 0; sie_wdata = 0;
    sram_rdata = 0;
    for (int i = 0; i < 2048; i++) mem[i] = 8'h00;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    t_reset();
    t_nak_unarmed();
    t_rx_wrap();
    t_overrun();
    t_tx();
    t_double();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule